// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A full address is captured whenever either of two load strobes is high at a rising clock edge. From then on, the upper address bits stay fixed. The low-order bits step through a four-word burst, and each step happens only on an edge where the advance input is high. A strobe may arrive on any cycle and always restarts the burst from the newly captured address.

The low bits follow one of two orderings, picked by a mode input:

- **Linear:** the start value plus the burst count, wrapping within the burst.
- **Interleaved:** the start value XOR the burst count.

A low level on the mode input selects interleaved order, so a tied-off mode input gives interleaved bursts. The block also outputs the current position within the burst. It has a synchronous, active-high reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high at a rising edge, the block clears `addr_o` to zero and `burst_idx_o` to zero on that edge.
- R2: A high `load_a_i` at a rising edge captures `addr_i`. After that edge, `addr_o` equals the captured address and `burst_idx_o` is 0.
- R3: A high `load_b_i` at a rising edge behaves the same way as `load_a_i`. The same holds when both strobes are high together.
- R4: With both strobes low and `adv_i` high at an edge, `burst_idx_o` increases by one. After 3 it wraps to 0.
- R5: With both strobes low and `adv_i` low at an edge, `addr_o` and `burst_idx_o` keep their values, provided `linear_i` does not change.
- R6: When `linear_i` is 1 (linear order), bits [1:0] of `addr_o` equal (start + `burst_idx_o`) mod 4. Here start is bits [1:0] of the captured address.
- R7: When `linear_i` is 0 (interleaved order, the tied-off default), bits [1:0] of `addr_o` equal start XOR `burst_idx_o`.
- R8: Bits above bit 1 of `addr_o` change only on an edge where a strobe is high. Changes on `addr_i` without a strobe have no effect on them.
- R9: When a strobe and `adv_i` are high on the same edge, the load wins. The result is the new address with `burst_idx_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Address captured on a strobe |
| load_a_i | input | 1 | First load strobe |
| load_b_i | input | 1 | Second load strobe |
| adv_i | input | 1 | Advance the burst by one word |
| linear_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current word address |
| burst_idx_o | output | BURST_W | Position within the burst (0..3) |

## Verification
The ordering checks need a stable reference, so they compare consecutive cycles only when `linear_i` has the same value on both. The hold check also requires that `linear_i` stays still. The bench changes the mode input only on the cycle of a load strobe, which keeps every burst within these assumptions. All inputs are driven one nanosecond after the rising edge, so they are always settled well before the next edge samples them.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   // Encoding of the ordering mode input.
   typedef enum logic {
      ORDER_INTERLEAVED = 1'b0,
      ORDER_LINEAR      = 1'b1
   } order_e;

   // Burst step request derived from the strobes and the advance input.
   typedef enum logic [1:0] {
      STEP_HOLD    = 2'd0,
      STEP_ADVANCE = 2'd1,
      STEP_LOAD    = 2'd2
   } step_e;

   function automatic step_e pick_step(input logic any_load, input logic adv);
      if (any_load)  return STEP_LOAD;
      else if (adv)  return STEP_ADVANCE;
      else           return STEP_HOLD;
   endfunction
endpackage

// File: rtl/bsq_capture.sv
module bsq_capture
   import bsq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  step_e                     step_i,
   input  logic [ADDR_W-1:0]         addr_i,
   output logic [ADDR_W-BURST_W-1:0] upper_o,
   output logic [BURST_W-1:0]        start_o
);
   localparam int UPPER_W = ADDR_W - BURST_W;

   logic [UPPER_W-1:0] upper_q;
   logic [BURST_W-1:0] start_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         upper_q <= '0;
         start_q <= '0;
      end else if (step_i == STEP_LOAD) begin
         upper_q <= addr_i[ADDR_W-1:BURST_W];
         start_q <= addr_i[BURST_W-1:0];
      end
   end

   assign upper_o = upper_q;
   assign start_o = start_q;
endmodule

// File: rtl/bsq_counter.sv
module bsq_counter
   import bsq_pkg::*;
#(
   parameter int BURST_W = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  step_e              step_i,
   output logic [BURST_W-1:0] count_o
);
   logic [BURST_W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q <= '0;
      end else begin
         unique case (step_i)
            STEP_LOAD:    count_q <= '0;
            STEP_ADVANCE: count_q <= count_q + 1'b1;
            default:      count_q <= count_q;
         endcase
      end
   end

   assign count_o = count_q;
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
   import bsq_pkg::*;
#(
   parameter int BURST_W    = 2,
   parameter bit HAS_LINEAR = 1'b1
) (
   input  logic [BURST_W-1:0] start_i,
   input  logic [BURST_W-1:0] count_i,
   input  logic               linear_i,
   output logic [BURST_W-1:0] low_o
);
   logic [BURST_W-1:0] inter_w;

   // Interleaved order: bitwise XOR of start and count.
   for (genvar b = 0; b < BURST_W; b++) begin : g_xor
      assign inter_w[b] = start_i[b] ^ count_i[b];
   end

   if (HAS_LINEAR) begin : g_both
      logic [BURST_W-1:0] lin_w;
      assign lin_w = start_i + count_i;   // wraps modulo burst length
      always_comb begin
         if (order_e'(linear_i) == ORDER_LINEAR) low_o = lin_w;
         else                                    low_o = inter_w;
      end
   end else begin : g_inter_only
      logic unused_mode;
      assign unused_mode = linear_i;
      assign low_o = inter_w;
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int BURST_W    = 2,
   parameter bit HAS_LINEAR = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               load_a_i,
   input  logic               load_b_i,
   input  logic               adv_i,
   input  logic               linear_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [BURST_W-1:0] burst_idx_o
);
   localparam int UPPER_W = ADDR_W - BURST_W;

   if (BURST_W < 1) begin : g_bad_burst
      $error("burst_addr_seq: BURST_W must be at least 1");
   end
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BURST_W");
   end

   step_e              step_w;
   logic [UPPER_W-1:0] upper_w;
   logic [BURST_W-1:0] start_w;
   logic [BURST_W-1:0] count_w;
   logic [BURST_W-1:0] low_w;

   // A load on either strobe overrides an advance.
   assign step_w = pick_step(load_a_i | load_b_i, adv_i);

   bsq_capture #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_capture (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .step_i  (step_w),
      .addr_i  (addr_i),
      .upper_o (upper_w),
      .start_o (start_w)
   );

   bsq_counter #(.BURST_W(BURST_W)) u_counter (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .step_i  (step_w),
      .count_o (count_w)
   );

   bsq_order_map #(.BURST_W(BURST_W), .HAS_LINEAR(HAS_LINEAR)) u_map (
      .start_i  (start_w),
      .count_i  (count_w),
      .linear_i (linear_i),
      .low_o    (low_w)
   );

   assign addr_o      = {upper_w, low_w};
   assign burst_idx_o = count_w;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
   parameter int ADDR_W  = 20,
   parameter int BURST_W = 2
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic               load_a_i,
   input logic               load_b_i,
   input logic               adv_i,
   input logic               linear_i,
   input logic [ADDR_W-1:0]  addr_o,
   input logic [BURST_W-1:0] burst_idx_o
);
   logic [BURST_W-1:0] low_w;
   logic [BURST_W-1:0] key_w;
   logic               load_w;

   assign low_w  = addr_o[BURST_W-1:0];
   assign key_w  = low_w ^ burst_idx_o;
   assign load_w = load_a_i | load_b_i;

   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      $past(rst_i) |-> (addr_o == '0 && burst_idx_o == '0)); // R1

   AST_LOAD_A: assert property (@(posedge clk_i) disable iff (rst_i)
      load_a_i |=> (addr_o == $past(addr_i) && burst_idx_o == '0)); // R2

   AST_LOAD_B: assert property (@(posedge clk_i) disable iff (rst_i)
      load_b_i |=> (addr_o == $past(addr_i) && burst_idx_o == '0)); // R3

   AST_ADVANCE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_w && adv_i) |=> burst_idx_o == BURST_W'($past(burst_idx_o) + 1'b1)); // R4

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_w && !adv_i) |=> ($stable(burst_idx_o) && (!$stable(linear_i) || $stable(addr_o)))); // R5

   AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_w && adv_i && linear_i) |=> (!linear_i || low_w == BURST_W'($past(low_w) + 1'b1))); // R6

   AST_INTERLEAVE_KEY: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_w && !linear_i) |=> (linear_i || key_w == $past(key_w))); // R7

   AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_w |=> $stable(addr_o[ADDR_W-1:BURST_W])); // R8

   AST_LOAD_PRIORITY: assert property (@(posedge clk_i) disable iff (rst_i)
      (load_w && adv_i) |=> burst_idx_o == '0); // R9
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_bsq_checker (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .addr_i      (addr_i),
   .load_a_i    (load_a_i),
   .load_b_i    (load_b_i),
   .adv_i       (adv_i),
   .linear_i    (linear_i),
   .addr_o      (addr_o),
   .burst_idx_o (burst_idx_o)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
   localparam int AW = 20;
   localparam int BW = 2;

   logic          clk_i = 1'b0;
   logic          rst_i = 1'b1;
   logic [AW-1:0] addr_i = '0;
   logic          load_a_i = 1'b0;
   logic          load_b_i = 1'b0;
   logic          adv_i = 1'b0;
   logic          linear_i = 1'b0;
   logic [AW-1:0] addr_o;
   logic [BW-1:0] burst_idx_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk_i = ~clk_i;

   burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) dut (
      .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i),
      .load_a_i(load_a_i), .load_b_i(load_b_i), .adv_i(adv_i),
      .linear_i(linear_i), .addr_o(addr_o), .burst_idx_o(burst_idx_o)
   );

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base,
                                              input int n, input bit lin);
      logic [BW-1:0] s;
      logic [BW-1:0] c;
      s = base[BW-1:0];
      c = BW'(n);
      return {base[AW-1:BW], lin ? BW'(s + c) : (s ^ c)};
   endfunction

   task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // One edge; inputs were set 1 ns after the previous edge, sample 1 ns after this one.
   task automatic tick();
      @(posedge clk_i);
      #1;
      load_a_i = 1'b0;
      load_b_i = 1'b0;
      adv_i    = 1'b0;
   endtask

   task automatic t_reset();
      rst_i = 1'b1;
      addr_i = 20'hFFFFF;
      load_a_i = 1'b1;
      adv_i = 1'b1;
      tick();
      tick();
      chk("R1 addr after reset", addr_o, '0);
      chk("R1 index after reset", AW'(burst_idx_o), '0);
      rst_i = 1'b0;
   endtask

   task automatic t_linear_a();
      logic [AW-1:0] base = 20'hABCD6;
      linear_i = 1'b1;
      addr_i = base;
      load_a_i = 1'b1;
      tick();
      chk("R2 load via first strobe", addr_o, base);
      chk("R2 index zero after load", AW'(burst_idx_o), '0);
      for (int n = 1; n <= 4; n++) begin
         adv_i = 1'b1;
         addr_i = 20'h5555A;   // must not be picked up
         tick();
         chk($sformatf("R6 linear step %0d", n), addr_o, exp_addr(base, n, 1'b1));
         chk($sformatf("R4 index step %0d", n), AW'(burst_idx_o), AW'(n % 4));
         chk($sformatf("R8 upper fixed step %0d", n), {addr_o[AW-1:BW], 2'b00},
             {base[AW-1:BW], 2'b00});
      end
   endtask

   task automatic t_interleave_b();
      logic [AW-1:0] base = 20'h12343;
      linear_i = 1'b0;
      addr_i = base;
      load_b_i = 1'b1;
      tick();
      chk("R3 load via second strobe", addr_o, base);
      for (int n = 1; n <= 3; n++) begin
         adv_i = 1'b1;
         tick();
         chk($sformatf("R7 interleaved step %0d", n), addr_o, exp_addr(base, n, 1'b0));
      end
   endtask

   task automatic t_hold();
      logic [AW-1:0] base = 20'h0F0F1;
      linear_i = 1'b1;
      addr_i = base;
      load_a_i = 1'b1;
      tick();
      adv_i = 1'b1;
      tick();
      for (int k = 0; k < 3; k++) begin
         addr_i = 20'hFFFFF;
         tick();
         chk("R5 hold address", addr_o, exp_addr(base, 1, 1'b1));
         chk("R5 hold index", AW'(burst_idx_o), AW'(1));
      end
   endtask

   task automatic t_priority();
      logic [AW-1:0] base = 20'h77772;
      logic [AW-1:0] nxt = 20'h3C3C1;
      linear_i = 1'b0;
      addr_i = base;
      load_a_i = 1'b1;
      tick();
      adv_i = 1'b1;
      tick();
      adv_i = 1'b1;
      tick();
      chk("R7 interleaved before reload", addr_o, exp_addr(base, 2, 1'b0));
      addr_i = nxt;
      load_b_i = 1'b1;
      adv_i = 1'b1;
      tick();
      chk("R9 load beats advance addr", addr_o, nxt);
      chk("R9 load beats advance index", AW'(burst_idx_o), '0);
      addr_i = 20'h00010;
      load_a_i = 1'b1;
      load_b_i = 1'b1;
      tick();
      chk("R3 both strobes load", addr_o, 20'h00010);
   endtask

   initial begin
      t_reset();
      t_linear_a();
      t_interleave_b();
      t_hold();
      t_priority();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule